// File: doc/BRIEF.md
# Two-Operand Integer ALU with Bit Operations

This block is the purely combinational integer execution unit of a small RISC pipeline. It takes two 32-bit source operands, called b and c, and a 5-bit operation code. It also takes the current carry and overflow flags. In the same cycle it returns a result, a destination write-enable, and next values for the zero, negative, carry and overflow flags. Decode, the register file and condition evaluation sit around it and are not part of it.

The arithmetic operations are:

- plain add and subtract;
- add and subtract that also use the incoming carry;
- reverse subtract and reverse compare, which use c minus b;
- scaled add and subtract, where c is shifted left by 1, 2 or 3 places before the addition.

The logic and bit operations are:

- the bitwise operations and signed maximum and minimum;
- single-bit set, clear, toggle and test, with the bit position taken from c;
- low-bit masks and their complements, with the mask width taken from c.

Compare and test operations only update flags. They hold the write-enable low, but the value they compute still appears on the result port.

Top module: `alu_core`

## Requirements
- R1: Op 0 gives b + c and op 1 gives b + c + carry_i. The carry flag is the carry out of bit 31, and the overflow flag is set when the signed sum falls outside the 32-bit signed range.
- R2: Op 2 gives b - c and op 3 gives b - c - carry_i. The carry flag is set when an unsigned borrow occurs, and the overflow flag marks signed overflow.
- R3: Op 4 gives c - b, with the same borrow and overflow rules as R2.
- R4: Ops 7, 8 and 9 give b + (c << 1), b + (c << 2) and b + (c << 3). Ops 10, 11 and 12 give b minus the same shifted values. Bits shifted out above bit 31 are dropped, and the carry flag comes only from the final add or subtract.
- R5: Op 5 sets the flags from b - c and op 6 sets them from c - b, using the R2 rules. Both hold wr_en_o low, and res_o shows the difference.
- R6: Op 13 gives b AND c, op 14 gives b OR c, op 15 gives b XOR c, and op 16 gives b AND NOT c. For these, the carry and overflow outputs equal carry_i and ovf_i.
- R7: Op 17 gives the larger and op 18 the smaller of b and c, both taken as signed values. The carry and overflow flags pass through unchanged.
- R8: With n = c[4:0], op 20 gives b with bit n set, op 21 gives b with bit n cleared, and op 22 gives b with bit n inverted. The upper bits of c are ignored, and carry and overflow pass through.
- R9: With n = c[4:0], op 24 gives b AND M and op 25 gives b AND NOT M, where M has bits 0 to n set. For n = 31 the mask covers all 32 bits. Carry and overflow pass through.
- R10: Op 19 gives b AND c and op 23 gives b AND (1 << c[4:0]). Both are for flags only: wr_en_o is low, and carry and overflow pass through.
- R11: Ops 26 to 31 are unused. For these, res_o is 0, wr_en_o is low, zero_o is 1, neg_o is 0, and carry and overflow pass through.
- R12: For every op, zero_o is 1 exactly when res_o is all zeros, and neg_o equals res_o bit 31. wr_en_o is high for every op except 5, 6, 19, 23 and 26 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_b | input | 32 | First source operand (b) |
| opnd_c | input | 32 | Second source operand (c); its low 5 bits are the bit index for bit operations |
| op_sel | input | 5 | Operation code as listed in the requirements |
| carry_i | input | 1 | Current carry flag |
| ovf_i | input | 1 | Current overflow flag |
| res_o | output | 32 | Computed value |
| wr_en_o | output | 1 | Destination write-enable |
| zero_o | output | 1 | Next zero flag |
| neg_o | output | 1 | Next negative flag |
| carry_o | output | 1 | Next carry flag |
| ovf_o | output | 1 | Next overflow flag |

## Verification
The block holds no state, so any wrong internal decision shows up at the ports in the same cycle as the operands that cause it. Typical faults are a wrong carry-in, an inverted borrow sense, a mask that is off by one, or a misrouted op class. Each of these gives a wrong result or flag bit on that vector. The bench therefore compares every output against a behavioural model on every clock. It uses directed corner operands at the carry, overflow, index-wrap and full-mask boundaries, and then many pseudo-random vectors that cover all 32 op codes.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 5'd0,
    OP_ADC   = 5'd1,
    OP_SUB   = 5'd2,
    OP_SBC   = 5'd3,
    OP_RSUB  = 5'd4,
    OP_CMP   = 5'd5,
    OP_RCMP  = 5'd6,
    OP_ADDS1 = 5'd7,
    OP_ADDS2 = 5'd8,
    OP_ADDS3 = 5'd9,
    OP_SUBS1 = 5'd10,
    OP_SUBS2 = 5'd11,
    OP_SUBS3 = 5'd12,
    OP_AND   = 5'd13,
    OP_OR    = 5'd14,
    OP_XOR   = 5'd15,
    OP_ANDN  = 5'd16,
    OP_SMAX  = 5'd17,
    OP_SMIN  = 5'd18,
    OP_TEST  = 5'd19,
    OP_BSET  = 5'd20,
    OP_BCLR  = 5'd21,
    OP_BFLIP = 5'd22,
    OP_BTEST = 5'd23,
    OP_LMASK = 5'd24,
    OP_HMASK = 5'd25
  } alu_op_e;

  localparam logic [OP_W-1:0] OP_LAST = 5'd25;

  function automatic logic op_is_arith(input alu_op_e op);
    return (op <= OP_SUBS3);
  endfunction

  function automatic logic op_is_valid(input alu_op_e op);
    return (op <= OP_LAST);
  endfunction

  function automatic logic op_flags_only(input alu_op_e op);
    return (op == OP_CMP) || (op == OP_RCMP) ||
           (op == OP_TEST) || (op == OP_BTEST);
  endfunction

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);

  logic [WIDTH:0] full;

  always_comb begin
    full   = {1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, cin_i};
    sum_o  = full[WIDTH-1:0];
    cout_o = full[WIDTH];
    ovf_o  = (x_i[WIDTH-1] == y_i[WIDTH-1]) && (full[WIDTH-1] != x_i[WIDTH-1]);
  end

endmodule

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] c_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o
);

  localparam int MAX_SCALE = 3;

  logic [WIDTH-1:0] scaled [MAX_SCALE+1];
  logic [WIDTH-1:0] x_op, y_op;
  logic             cin, borrow_mode, cout;

  // shifted copies of c; bits above the top are dropped
  for (genvar k = 0; k <= MAX_SCALE; k++) begin : g_scale
    assign scaled[k] = c_i << k;
  end

  always_comb begin
    x_op        = b_i;
    y_op        = scaled[0];
    cin         = 1'b0;
    borrow_mode = 1'b0;
    unique case (op_i)
      OP_ADC:   cin = carry_i;
      OP_SUB,
      OP_CMP:   begin y_op = ~scaled[0]; cin = 1'b1;     borrow_mode = 1'b1; end
      OP_SBC:   begin y_op = ~scaled[0]; cin = ~carry_i; borrow_mode = 1'b1; end
      OP_RSUB,
      OP_RCMP:  begin x_op = c_i; y_op = ~b_i; cin = 1'b1; borrow_mode = 1'b1; end
      OP_ADDS1: y_op = scaled[1];
      OP_ADDS2: y_op = scaled[2];
      OP_ADDS3: y_op = scaled[3];
      OP_SUBS1: begin y_op = ~scaled[1]; cin = 1'b1; borrow_mode = 1'b1; end
      OP_SUBS2: begin y_op = ~scaled[2]; cin = 1'b1; borrow_mode = 1'b1; end
      OP_SUBS3: begin y_op = ~scaled[3]; cin = 1'b1; borrow_mode = 1'b1; end
      default:  ;
    endcase
  end

  alu_adder #(.WIDTH(WIDTH)) u_add (
    .x_i   (x_op),
    .y_i   (y_op),
    .cin_i (cin),
    .sum_o (sum_o),
    .cout_o(cout),
    .ovf_o (ovf_o)
  );

  assign carry_o = borrow_mode ? ~cout : cout;

  // R2: a subtract of equal operands never borrows
  always_comb begin
    if ((op_i == OP_SUB) && (b_i == c_i)) begin
      p_sub_equal_r2: assert (!carry_o && (sum_o == '0))
        else $error("R2: equal subtract produced borrow or nonzero");
    end
  end

endmodule

// File: rtl/alu_bitlogic.sv
module alu_bitlogic
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] c_i,
  output logic [WIDTH-1:0] res_o
);

  localparam int               IDX_W   = $clog2(WIDTH);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(WIDTH - 1);

  logic [IDX_W-1:0] idx;
  logic [WIDTH-1:0] one_hot, low_mask;
  logic             b_gt_c;

  assign idx      = c_i[IDX_W-1:0];
  assign one_hot  = {{(WIDTH-1){1'b0}}, 1'b1} << idx;
  assign low_mask = {WIDTH{1'b1}} >> (IDX_TOP - idx);
  assign b_gt_c   = $signed(b_i) > $signed(c_i);

  always_comb begin
    unique case (op_i)
      OP_AND,
      OP_TEST:  res_o = b_i & c_i;
      OP_OR:    res_o = b_i | c_i;
      OP_XOR:   res_o = b_i ^ c_i;
      OP_ANDN:  res_o = b_i & ~c_i;
      OP_SMAX:  res_o = b_gt_c ? b_i : c_i;
      OP_SMIN:  res_o = b_gt_c ? c_i : b_i;
      OP_BSET:  res_o = b_i | one_hot;
      OP_BCLR:  res_o = b_i & ~one_hot;
      OP_BFLIP: res_o = b_i ^ one_hot;
      OP_BTEST: res_o = b_i & one_hot;
      OP_LMASK: res_o = b_i & low_mask;
      OP_HMASK: res_o = b_i & ~low_mask;
      default:  res_o = '0;
    endcase
  end

  // R8, R9, R7 checks on the produced value
  always_comb begin
    if (op_i == OP_BSET) begin
      p_bset_bit_r8: assert (res_o[idx] && ((res_o & ~one_hot) == (b_i & ~one_hot)))
        else $error("R8: set bit missing or other bits altered");
    end
    if (op_i == OP_BFLIP) begin
      p_bflip_single_r8: assert ($countones(res_o ^ b_i) == 1)
        else $error("R8: toggle changed other than one bit");
    end
    if ((op_i == OP_LMASK) && (idx == IDX_TOP)) begin
      p_mask_full_r9: assert (res_o == b_i)
        else $error("R9: full mask altered operand");
    end
    if (op_i == OP_SMAX) begin
      p_max_bound_r7: assert (($signed(res_o) >= $signed(b_i)) && ($signed(res_o) >= $signed(c_i)))
        else $error("R7: max below an operand");
    end
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [WIDTH-1:0] opnd_c,
  input  logic [OP_W-1:0]  op_sel,
  input  logic             carry_i,
  input  logic             ovf_i,
  output logic [WIDTH-1:0] res_o,
  output logic             wr_en_o,
  output logic             zero_o,
  output logic             neg_o,
  output logic             carry_o,
  output logic             ovf_o
);

  alu_op_e          op;
  logic [WIDTH-1:0] arith_res, logic_res;
  logic             arith_c, arith_v, is_arith;

  assign op       = alu_op_e'(op_sel);
  assign is_arith = op_is_arith(op);

  alu_arith #(.WIDTH(WIDTH)) u_arith (
    .op_i    (op),
    .b_i     (opnd_b),
    .c_i     (opnd_c),
    .carry_i (carry_i),
    .sum_o   (arith_res),
    .carry_o (arith_c),
    .ovf_o   (arith_v)
  );

  alu_bitlogic #(.WIDTH(WIDTH)) u_bits (
    .op_i  (op),
    .b_i   (opnd_b),
    .c_i   (opnd_c),
    .res_o (logic_res)
  );

  always_comb begin
    res_o   = is_arith ? arith_res : logic_res;
    carry_o = is_arith ? arith_c   : carry_i;
    ovf_o   = is_arith ? arith_v   : ovf_i;
    zero_o  = (res_o == '0);
    neg_o   = res_o[WIDTH-1];
    wr_en_o = op_is_valid(op) && !op_flags_only(op);
  end

  // port-level checks across the two datapaths
  always_comb begin
    if ((op == OP_ADD) && ovf_o) begin
      p_add_ovf_sign_r1: assert ((opnd_b[WIDTH-1] == opnd_c[WIDTH-1]) && (res_o[WIDTH-1] != opnd_b[WIDTH-1]))
        else $error("R1: overflow flagged without sign change");
    end
    if ((op == OP_CMP) || (op == OP_RCMP)) begin
      p_cmp_nowrite_r5: assert (!wr_en_o)
        else $error("R5: compare enabled a write");
    end
    if ((op >= OP_AND) && (op <= OP_ANDN)) begin
      p_logic_keep_cv_r6: assert ((carry_o == carry_i) && (ovf_o == ovf_i))
        else $error("R6: logic op changed carry or overflow");
    end
    if (!op_is_valid(op)) begin
      p_unused_idle_r11: assert ((res_o == '0) && !wr_en_o)
        else $error("R11: unused op produced output");
    end
  end

endmodule

// File: tb/alu_core_test.sv
`timescale 1ns/1ps
module alu_core_test;

  logic        clk, rst_n;
  logic [31:0] opnd_b, opnd_c, res_o;
  logic [4:0]  op_sel;
  logic        carry_i, ovf_i, wr_en_o, zero_o, neg_o, carry_o, ovf_o;
  int          total, bad;

  alu_core uut (
    .opnd_b(opnd_b), .opnd_c(opnd_c), .op_sel(op_sel),
    .carry_i(carry_i), .ovf_i(ovf_i), .res_o(res_o), .wr_en_o(wr_en_o),
    .zero_o(zero_o), .neg_o(neg_o), .carry_o(carry_o), .ovf_o(ovf_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic out_of_range(input longint v);
    return (v > 64'sd2147483647) || (v < -64'sd2147483648);
  endfunction

  task automatic model(input logic [4:0] op, input logic [31:0] b, input logic [31:0] c,
                       input logic ci, input logic vi,
                       output logic [31:0] r, output logic w, output logic co,
                       output logic vo, output string tag);
    longint ub, uc, sb, sc, uv, sv;
    logic [31:0] cs, oh, msk;
    int k, n;
    ub = longint'({32'd0, b}); uc = longint'({32'd0, c});
    sb = longint'($signed(b)); sc = longint'($signed(c));
    n  = int'(c[4:0]);
    oh = 32'd1 << n;
    msk = 32'hFFFF_FFFF >> (31 - n);
    co = ci; vo = vi; r = 32'd0; uv = 0; sv = 0;
    w  = !(op == 5 || op == 6 || op == 19 || op == 23 || op >= 26);
    case (op)
      0, 1: begin uv = ub + uc + longint'(op == 1 ? ci : 1'b0);
                  sv = sb + sc + longint'(op == 1 ? ci : 1'b0);
                  co = uv[32]; tag = "R1"; end
      2, 3, 5: begin uv = ub - uc - longint'(op == 3 ? ci : 1'b0);
                  sv = sb - sc - longint'(op == 3 ? ci : 1'b0);
                  co = ub < uc + longint'(op == 3 ? ci : 1'b0);
                  tag = (op == 5) ? "R5" : "R2"; end
      4, 6: begin uv = uc - ub; sv = sc - sb; co = uc < ub;
                  tag = (op == 6) ? "R5" : "R3"; end
      7, 8, 9, 10, 11, 12: begin
                  k  = (op <= 9) ? int'(op) - 6 : int'(op) - 9;
                  cs = c << k;
                  if (op <= 9) begin
                    uv = ub + longint'({32'd0, cs}); sv = sb + longint'($signed(cs)); co = uv[32];
                  end else begin
                    uv = ub - longint'({32'd0, cs}); sv = sb - longint'($signed(cs));
                    co = ub < longint'({32'd0, cs});
                  end
                  tag = "R4"; end
      13: begin r = b & c;  tag = "R6"; end
      14: begin r = b | c;  tag = "R6"; end
      15: begin r = b ^ c;  tag = "R6"; end
      16: begin r = b & ~c; tag = "R6"; end
      17: begin r = (sb > sc) ? b : c; tag = "R7"; end
      18: begin r = (sb < sc) ? b : c; tag = "R7"; end
      19: begin r = b & c;  tag = "R10"; end
      20: begin r = b | oh; tag = "R8"; end
      21: begin r = b & ~oh; tag = "R8"; end
      22: begin r = b ^ oh; tag = "R8"; end
      23: begin r = b & oh; tag = "R10"; end
      24: begin r = b & msk; tag = "R9"; end
      25: begin r = b & ~msk; tag = "R9"; end
      default: begin r = 32'd0; tag = "R11"; end
    endcase
    if (op <= 12) begin
      r  = uv[31:0];
      vo = out_of_range(sv);
    end
  endtask

  task automatic apply(input logic [4:0] op, input logic [31:0] b, input logic [31:0] c,
                       input logic ci, input logic vi);
    logic [31:0] er; logic ew, ec, ev, ez, en; string tag;
    @(negedge clk);
    op_sel = op; opnd_b = b; opnd_c = c; carry_i = ci; ovf_i = vi;
    @(posedge clk); #2;
    model(op, b, c, ci, vi, er, ew, ec, ev, tag);
    ez = (er == 32'd0); en = er[31];  // R12 flag rules
    total++;
    if (res_o !== er || wr_en_o !== ew || zero_o !== ez || neg_o !== en ||
        carry_o !== ec || ovf_o !== ev) begin
      bad++;
      $display("FAIL %s op=%0d b=%h c=%h ci=%b vi=%b: got r=%h w=%b z=%b n=%b c=%b v=%b exp r=%h w=%b z=%b n=%b c=%b v=%b",
               tag, op, b, c, ci, vi, res_o, wr_en_o, zero_o, neg_o, carry_o, ovf_o,
               er, ew, ez, en, ec, ev);
    end
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0; rst_n = 1'b0;
    opnd_b = '0; opnd_c = '0; op_sel = '0; carry_i = 1'b0; ovf_i = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle inputs: add of zeros, zero flag set (R12)
    apply(5'd0, 32'd0, 32'd0, 1'b0, 1'b0);
    // R1 carry out, overflow, carry-in
    apply(5'd0, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0);
    apply(5'd0, 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b0);
    apply(5'd1, 32'h7FFF_FFFE, 32'd1, 1'b1, 1'b0);
    // R2 borrow and subtract with carry
    apply(5'd2, 32'd1, 32'd2, 1'b0, 1'b0);
    apply(5'd2, 32'h8000_0000, 32'd1, 1'b0, 1'b0);
    apply(5'd3, 32'd5, 32'd5, 1'b1, 1'b0);
    apply(5'd3, 32'd5, 32'd4, 1'b1, 1'b1);
    // R3 reverse subtract
    apply(5'd4, 32'd3, 32'd10, 1'b0, 1'b0);
    apply(5'd4, 32'd10, 32'd3, 1'b1, 1'b0);
    // R5 compares
    apply(5'd5, 32'd7, 32'd7, 1'b1, 1'b1);
    apply(5'd6, 32'd7, 32'd2, 1'b0, 1'b0);
    // R4 scaled with dropped high bits
    apply(5'd7, 32'd1, 32'hC000_0001, 1'b0, 1'b0);
    apply(5'd9, 32'hFFFF_FFF8, 32'd1, 1'b0, 1'b0);
    apply(5'd11, 32'd3, 32'd1, 1'b0, 1'b0);
    apply(5'd12, 32'd8, 32'h2000_0001, 1'b1, 1'b0);
    // R6 logic keeps C and V
    apply(5'd16, 32'hF0F0_F0F0, 32'hFF00_FF00, 1'b1, 1'b1);
    apply(5'd15, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1, 1'b0);
    // R7 signed max/min
    apply(5'd17, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1);
    apply(5'd18, 32'hFFFF_FFFF, 32'd1, 1'b1, 1'b0);
    // R8 index uses low 5 bits only
    apply(5'd20, 32'd0, 32'hFFFF_FFFF, 1'b0, 1'b0);
    apply(5'd21, 32'hFFFF_FFFF, 32'h0000_0020, 1'b1, 1'b1);
    apply(5'd22, 32'h8000_0000, 32'd31, 1'b0, 1'b0);
    // R9 masks at both ends
    apply(5'd24, 32'hDEAD_BEEF, 32'd31, 1'b0, 1'b0);
    apply(5'd24, 32'hDEAD_BEEF, 32'd0, 1'b0, 1'b0);
    apply(5'd25, 32'hDEAD_BEEF, 32'd7, 1'b1, 1'b1);
    // R10 tests without write
    apply(5'd19, 32'h0F0F_0000, 32'h00F0_FFFF, 1'b1, 1'b0);
    apply(5'd23, 32'h0000_0010, 32'd4, 1'b0, 1'b1);
    // R11 unused codes
    apply(5'd26, 32'h1234_5678, 32'h1, 1'b1, 1'b1);
    apply(5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0);
    // broad sweep across all codes
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] rb, rc;
      rb = $urandom; rc = $urandom;
      if (i % 7 == 0) rc = rc & 32'h3F;
      if (i % 11 == 0) rb = rc;
      apply(5'(i % 32), rb, rc, 1'((i / 32) % 2), 1'((i / 64) % 2));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule